// File: doc/BRIEF.md
# Fault-Aware Shared Flit Buffer

This block is the input buffer for one pair of physical input channels in a network-on-chip router. The two channels each carry four virtual channels, which gives eight virtual channels. All eight draw their flit slots from one common pool. A slot-occupancy map hands out free slots, and each virtual channel threads its own slots into a FIFO through a next-pointer table. Each physical channel has its own write port and its own read port. All four ports can act in the same cycle.

Each virtual channel has a small guaranteed share of the pool. A virtual channel can always fill that share, even when the other channels are heavily loaded. Any flit beyond the share comes from the common region, and only while enough free slots remain to honour every other channel's unused share.

When the output link that a virtual channel feeds has failed, the surrounding router raises a per-VC dead mask. The buffer then discards every flit held for that VC in one cycle and returns the slots to the pool. No exchange with any higher layer is needed. Routing, allocation, arbitration and fault detection are outside this block.

Top module: `sbuf_fault_buf`

## Requirements
- R1: After reset every virtual channel is empty, every bit of `credit_o` is 1, and `rd_valid_o` and `overflow_o` are 0.
- R2: Flits of one virtual channel are read back in the order they were written. An accepted read gives `rd_valid_o[p]`=1 with the head flit on `rd_flit_o[p]` in the cycle after the request.
- R3: Port 0 serves global VCs 0..3 and port 1 serves global VCs 4..7 (global VC = port*4 + `wr_vc_i`/`rd_vc_i`). Both write ports and both read ports operate independently in the same cycle.
- R4: While a virtual channel holds fewer than RSV (default 2) flits and is not dead, a write to it is always accepted.
- R5: A write that would take a slot from the common region is accepted only if the free-slot count exceeds the sum of the unused shares of all other VCs. With the defaults (32 slots), a single VC can hold 18 flits while the others are empty.
- R6: A refused write is dropped and is never read out. It raises `overflow_o[p]` for exactly the next cycle.
- R7: A read of an empty virtual channel is ignored: `rd_valid_o[p]` stays 0.
- R8: In the first cycle that `dead_vc_i[v]` is high, all flits of VC v are discarded and their slots return to the pool. Afterwards VC v reads as empty, and other VCs can use the freed space.
- R9: While `dead_vc_i[v]` is high, writes to VC v are dropped without raising an overflow, reads from VC v are ignored, and `credit_o[v]` is 0.
- R10: `credit_o[v]` is 1 exactly when a lone write to VC v would be accepted in that cycle.
- R11: Slots are never lost. The free-slot count plus the sum of per-VC occupancies always equals the pool depth, so after purges and reads the full capacity is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 2 | Write request, one per physical channel |
| wr_vc_i | input | 2x2 | Local VC of each write |
| wr_flit_i | input | 2xFLIT_W | Write data per port |
| rd_req_i | input | 2 | Read request per physical channel |
| rd_vc_i | input | 2x2 | Local VC of each read |
| dead_vc_i | input | 8 | Per-VC failed-link mask, purge and block |
| rd_valid_o | output | 2 | Read data valid, one cycle after request |
| rd_flit_o | output | 2xFLIT_W | Read data per port |
| credit_o | output | 8 | Per-VC write acceptance indication |
| overflow_o | output | 2 | Dropped-write pulse per port |

## Verification
The hardest state to reach is the boundary where the common region is exhausted while one VC still has its guaranteed share. A write to that VC must then succeed while a write to an already-served VC is refused. The bench reaches this state by pushing 18 flits into a single VC, so that the remaining free slots equal the other VCs' unused shares. It then writes a second VC on the other port until the extra write is refused. A purge follows on the full VC, and the bench shows that the refused VC is accepted again and that the full capacity returns.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned NUM_PC = 2;  // one pool serves exactly two physical channels

  function automatic int unsigned rsv_left(int unsigned cnt, int unsigned rsv);
    return (cnt >= rsv) ? 0 : rsv - cnt;
  endfunction
endpackage

// File: rtl/sbuf_free_map.sv
module sbuf_free_map #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_lo_i,
  input  logic             take_hi_i,
  input  logic [DEPTH-1:0] rel_mask_i,
  output logic [PTR_W-1:0] lo_o,
  output logic [PTR_W-1:0] hi_o,
  output logic [CNT_W-1:0] free_cnt_o,
  output logic [DEPTH-1:0] free_map_o
);
  logic [DEPTH-1:0] free_q, free_d;

  // lowest free slot feeds port 0, highest feeds port 1
  always_comb begin
    lo_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (free_q[i]) lo_o = PTR_W'(i);
    hi_o = '0;
    for (int i = 0; i < DEPTH; i++) if (free_q[i]) hi_o = PTR_W'(i);
  end

  always_comb begin
    free_d = free_q | rel_mask_i;
    if (take_lo_i) free_d[lo_o] = 1'b0;
    if (take_hi_i) free_d[hi_o] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= free_d;
  end

  assign free_cnt_o = CNT_W'($countones(free_q));
  assign free_map_o = free_q;
endmodule

// File: rtl/sbuf_vc_list.sv
module sbuf_vc_list #(
  parameter int unsigned PTR_W = 5,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PTR_W-1:0] push_ptr_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] link_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_o  <= '0;
    end else if (flush_i) begin
      cnt_o <= '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10: begin
          if (cnt_o == '0) head_o <= push_ptr_i;
          tail_o <= push_ptr_i;
          cnt_o  <= cnt_o + 1'b1;
        end
        2'b01: begin
          head_o <= link_i;
          cnt_o  <= cnt_o - 1'b1;
        end
        2'b11: begin
          // single entry popped while the new one links behind it
          head_o <= (cnt_o == CNT_W'(1)) ? push_ptr_i : link_i;
          tail_o <= push_ptr_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_admit.sv
module sbuf_admit #(
  parameter int unsigned NUM_VC = 8,
  parameter int unsigned NUM_PC = 2,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned RSV    = 2,
  localparam int unsigned VC_W  = $clog2(NUM_VC)
) (
  input  logic [NUM_VC-1:0][CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0]             free_cnt_i,
  input  logic [NUM_VC-1:0]            dead_i,
  input  logic [NUM_PC-1:0]            req_i,
  input  logic [NUM_PC-1:0][VC_W-1:0]  vc_i,
  output logic [NUM_PC-1:0]            grant_o,
  output logic [NUM_VC-1:0]            credit_o
);
  logic [NUM_VC-1:0][CNT_W-1:0] left, lft;
  logic [CNT_W-1:0]             total, f, t;

  always_comb begin
    total = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      left[v] = CNT_W'(sbuf_pkg::rsv_left(int'(cnt_i[v]), RSV));
      total   = total + left[v];
    end
    for (int v = 0; v < NUM_VC; v++)
      credit_o[v] = !dead_i[v] && (free_cnt_i > total - left[v]);
    // port 0 first, port 1 sees the pool after port 0's take
    f = free_cnt_i;
    t = total;
    lft = left;
    for (int p = 0; p < NUM_PC; p++) begin
      grant_o[p] = 1'b0;
      if (req_i[p] && !dead_i[vc_i[p]] && (f > t - lft[vc_i[p]])) begin
        grant_o[p] = 1'b1;
        f = f - 1'b1;
        if (lft[vc_i[p]] != '0) begin
          lft[vc_i[p]] = lft[vc_i[p]] - 1'b1;
          t = t - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbuf_fault_buf.sv
module sbuf_fault_buf #(
  parameter int unsigned VC_PER_PC = 4,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned FLIT_W    = 32,
  parameter int unsigned RSV       = 2,
  localparam int unsigned NUM_PC   = sbuf_pkg::NUM_PC,
  localparam int unsigned NUM_VC   = NUM_PC * VC_PER_PC,
  localparam int unsigned LVC_W    = (VC_PER_PC > 1) ? $clog2(VC_PER_PC) : 1,
  localparam int unsigned VC_W     = $clog2(NUM_VC)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PC-1:0]                wr_valid_i,
  input  logic [NUM_PC-1:0][LVC_W-1:0]     wr_vc_i,
  input  logic [NUM_PC-1:0][FLIT_W-1:0]    wr_flit_i,
  input  logic [NUM_PC-1:0]                rd_req_i,
  input  logic [NUM_PC-1:0][LVC_W-1:0]     rd_vc_i,
  input  logic [NUM_VC-1:0]                dead_vc_i,
  output logic [NUM_PC-1:0]                rd_valid_o,
  output logic [NUM_PC-1:0][FLIT_W-1:0]    rd_flit_o,
  output logic [NUM_VC-1:0]                credit_o,
  output logic [NUM_PC-1:0]                overflow_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]              lo_slot, hi_slot;
  logic [CNT_W-1:0]              free_cnt;
  logic [DEPTH-1:0]              free_map, rel_mask;
  logic [NUM_VC-1:0][CNT_W-1:0]  vc_cnt;
  logic [NUM_VC-1:0][PTR_W-1:0]  vc_head, vc_tail, vc_link, push_ptr;
  logic [NUM_VC-1:0]             vc_push, vc_pop;
  logic [NUM_PC-1:0][VC_W-1:0]   wr_gvc, rd_gvc;
  logic [NUM_PC-1:0][PTR_W-1:0]  slot;
  logic [NUM_PC-1:0]             grant, rd_ok;

  logic [PTR_W-1:0]  next_q  [DEPTH];
  logic [VC_W-1:0]   owner_q [DEPTH];
  logic [FLIT_W-1:0] ram_q   [DEPTH];

  for (genvar p = 0; p < NUM_PC; p++) begin : g_port
    assign wr_gvc[p] = VC_W'(p * VC_PER_PC) + VC_W'(wr_vc_i[p]);
    assign rd_gvc[p] = VC_W'(p * VC_PER_PC) + VC_W'(rd_vc_i[p]);
    assign rd_ok[p]  = rd_req_i[p] && (vc_cnt[rd_gvc[p]] != '0) && !dead_vc_i[rd_gvc[p]];
    assign slot[p]   = (p == 0) ? lo_slot : hi_slot;
  end

  sbuf_admit #(
    .NUM_VC(NUM_VC), .NUM_PC(NUM_PC), .CNT_W(CNT_W), .RSV(RSV)
  ) u_admit (
    .cnt_i      (vc_cnt),
    .free_cnt_i (free_cnt),
    .dead_i     (dead_vc_i),
    .req_i      (wr_valid_i),
    .vc_i       (wr_gvc),
    .grant_o    (grant),
    .credit_o   (credit_o)
  );

  // read pops plus bulk release of every slot owned by a dead VC
  always_comb begin
    for (int s = 0; s < DEPTH; s++)
      rel_mask[s] = !free_map[s] && dead_vc_i[owner_q[s]];
    for (int p = 0; p < NUM_PC; p++)
      if (rd_ok[p]) rel_mask[vc_head[rd_gvc[p]]] = 1'b1;
  end

  sbuf_free_map #(.DEPTH(DEPTH)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_lo_i  (grant[0]),
    .take_hi_i  (grant[1]),
    .rel_mask_i (rel_mask),
    .lo_o       (lo_slot),
    .hi_o       (hi_slot),
    .free_cnt_o (free_cnt),
    .free_map_o (free_map)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    always_comb begin
      vc_push[v]  = 1'b0;
      vc_pop[v]   = 1'b0;
      push_ptr[v] = lo_slot;
      for (int p = 0; p < NUM_PC; p++) begin
        if (grant[p] && wr_gvc[p] == VC_W'(v)) begin
          vc_push[v]  = 1'b1;
          push_ptr[v] = slot[p];
        end
        if (rd_ok[p] && rd_gvc[p] == VC_W'(v)) vc_pop[v] = 1'b1;
      end
    end

    assign vc_link[v] = next_q[vc_head[v]];

    sbuf_vc_list #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_list (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (vc_push[v]),
      .push_ptr_i (push_ptr[v]),
      .pop_i      (vc_pop[v]),
      .flush_i    (dead_vc_i[v]),
      .link_i     (vc_link[v]),
      .head_o     (vc_head[v]),
      .tail_o     (vc_tail[v]),
      .cnt_o      (vc_cnt[v])
    );
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NUM_PC; p++)
      if (grant[p]) ram_q[slot[p]] <= wr_flit_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) begin
        next_q[s]  <= '0;
        owner_q[s] <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_PC; p++) begin
        if (grant[p]) begin
          owner_q[slot[p]] <= wr_gvc[p];
          if (vc_cnt[wr_gvc[p]] != '0) next_q[vc_tail[wr_gvc[p]]] <= slot[p];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= '0;
      rd_flit_o  <= '0;
      overflow_o <= '0;
    end else begin
      for (int p = 0; p < NUM_PC; p++) begin
        rd_valid_o[p] <= rd_ok[p];
        if (rd_ok[p]) rd_flit_o[p] <= ram_q[vc_head[rd_gvc[p]]];
        overflow_o[p] <= wr_valid_i[p] && !grant[p] && !dead_vc_i[wr_gvc[p]];
      end
    end
  end
endmodule

// File: rtl/sbuf_fault_buf_chk.sv
module sbuf_fault_buf_chk #(
  parameter int unsigned VC_PER_PC = 4,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned RSV       = 2,
  localparam int unsigned NUM_PC   = sbuf_pkg::NUM_PC,
  localparam int unsigned NUM_VC   = NUM_PC * VC_PER_PC,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_PC-1:0]               wr_valid_i,
  input logic [NUM_PC-1:0]               rd_req_i,
  input logic [NUM_PC-1:0]               rd_valid_o,
  input logic [NUM_PC-1:0]               overflow_o,
  input logic [NUM_VC-1:0]               dead_vc_i,
  input logic [CNT_W-1:0]                free_cnt_i,
  input logic [NUM_VC-1:0][CNT_W-1:0]    vc_cnt_i
);
  logic [CNT_W:0] used_sum, unused_sum;

  always_comb begin
    used_sum   = '0;
    unused_sum = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      used_sum   = used_sum + (CNT_W + 1)'(vc_cnt_i[v]);
      unused_sum = unused_sum + (CNT_W + 1)'(sbuf_pkg::rsv_left(int'(vc_cnt_i[v]), RSV));
    end
  end

  assert_slot_conservation_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W + 1)'(free_cnt_i) + used_sum == (CNT_W + 1)'(DEPTH));

  assert_rsv_covered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CNT_W + 1)'(free_cnt_i) >= unused_sum);

  for (genvar p = 0; p < NUM_PC; p++) begin : g_pc
    assert_ovf_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o[p] |-> $past(wr_valid_i[p]));
    assert_rd_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o[p] |-> $past(rd_req_i[p]));
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assert_purge_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dead_vc_i[v] |=> (vc_cnt_i[v] == '0));
  end
endmodule

bind sbuf_fault_buf sbuf_fault_buf_chk #(
  .VC_PER_PC(VC_PER_PC), .DEPTH(DEPTH), .RSV(RSV)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .overflow_o (overflow_o),
  .dead_vc_i  (dead_vc_i),
  .free_cnt_i (free_cnt),
  .vc_cnt_i   (vc_cnt)
);

// File: tb/sbuf_fault_buf_bench.sv
`timescale 1ns/1ps
module sbuf_fault_buf_bench;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       wr_valid_i = '0;
  logic [1:0][1:0]  wr_vc_i = '0;
  logic [1:0][31:0] wr_flit_i = '0;
  logic [1:0]       rd_req_i = '0;
  logic [1:0][1:0]  rd_vc_i = '0;
  logic [7:0]       dead_vc_i = '0;
  logic [1:0]       rd_valid_o;
  logic [1:0][31:0] rd_flit_o;
  logic [7:0]       credit_o;
  logic [1:0]       overflow_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sbuf_fault_buf u_sbuf_fault_buf (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    wr_valid_i = '0;
    rd_req_i   = '0;
  endtask

  task automatic wr(input int p, input int lvc, input logic [31:0] d);
    wr_valid_i[p] = 1'b1;
    wr_vc_i[p]    = 2'(lvc);
    wr_flit_i[p]  = d;
    cyc();
    idle();
  endtask

  task automatic rd(input int p, input int lvc);
    rd_req_i[p] = 1'b1;
    rd_vc_i[p]  = 2'(lvc);
    cyc();
    idle();
  endtask

  task automatic t_reset();
    chk(credit_o == 8'hFF, "R1 credit", credit_o, 8'hFF);
    chk(rd_valid_o == 2'b00, "R1 rd_valid", rd_valid_o, 0);
    chk(overflow_o == 2'b00, "R1 overflow", overflow_o, 0);
  endtask

  task automatic t_empty_read();
    rd(0, 2);
    chk(rd_valid_o[0] == 1'b0, "R7 empty read", rd_valid_o[0], 0);
    rd(1, 3);
    chk(rd_valid_o[1] == 1'b0, "R7 empty read p1", rd_valid_o[1], 0);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < 3; i++) wr(0, 1, 32'hA000 + i);
    for (int i = 0; i < 3; i++) begin
      rd(0, 1);
      chk(rd_valid_o[0] && rd_flit_o[0] == 32'hA000 + i, "R2 order", rd_flit_o[0], 32'hA000 + i);
    end
    rd(0, 1);
    chk(rd_valid_o[0] == 1'b0, "R7 drained", rd_valid_o[0], 0);
  endtask

  task automatic t_dual();
    wr_valid_i = 2'b11;
    wr_vc_i    = {2'd2, 2'd0};
    wr_flit_i  = {32'hB006, 32'hB000};
    cyc();
    idle();
    rd_req_i = 2'b11;
    rd_vc_i  = {2'd2, 2'd0};
    cyc();
    idle();
    chk(rd_valid_o == 2'b11, "R3 both valid", rd_valid_o, 2'b11);
    chk(rd_flit_o[0] == 32'hB000, "R3 port0 data", rd_flit_o[0], 32'hB000);
    chk(rd_flit_o[1] == 32'hB006, "R3 port1 data", rd_flit_o[1], 32'hB006);
  endtask

  task automatic fill_vc0(input string req);
    int bad = 0;
    for (int i = 0; i < 18; i++) begin
      wr(0, 0, 32'hC000 + i);
      if (overflow_o[0]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_share();
    fill_vc0("R5 eighteen accepted");
    chk(credit_o[0] == 1'b0, "R10 credit vc0 low", credit_o[0], 0);
    chk(credit_o[1] == 1'b1, "R10 credit vc1 high", credit_o[1], 1);
    wr(0, 0, 32'hDEAD);
    chk(overflow_o[0] == 1'b1, "R6 overflow vc0", overflow_o[0], 1);
    cyc();
    chk(overflow_o[0] == 1'b0, "R6 single pulse", overflow_o[0], 0);
    wr(1, 1, 32'hE000);
    chk(overflow_o[1] == 1'b0, "R4 rsv first", overflow_o[1], 0);
    wr(1, 1, 32'hE001);
    chk(overflow_o[1] == 1'b0, "R4 rsv second", overflow_o[1], 0);
    chk(credit_o[5] == 1'b0, "R10 credit vc5 low", credit_o[5], 0);
    chk(credit_o[2] == 1'b1, "R10 credit vc2 high", credit_o[2], 1);
    wr(1, 1, 32'hBEEF);
    chk(overflow_o[1] == 1'b1, "R5 shared refused", overflow_o[1], 1);
  endtask

  task automatic t_purge();
    dead_vc_i[0] = 1'b1;
    cyc();
    wr_valid_i[0] = 1'b1; wr_vc_i[0] = 2'd0; wr_flit_i[0] = 32'hF00D;
    rd_req_i[0]   = 1'b1; rd_vc_i[0] = 2'd0;
    cyc();
    idle();
    chk(overflow_o[0] == 1'b0, "R9 no overflow", overflow_o[0], 0);
    chk(rd_valid_o[0] == 1'b0, "R9 read blocked", rd_valid_o[0], 0);
    chk(credit_o[0] == 1'b0, "R9 credit low", credit_o[0], 0);
    dead_vc_i[0] = 1'b0;
    #1;
    chk(credit_o[0] == 1'b1, "R8 credit back", credit_o[0], 1);
    rd(0, 0);
    chk(rd_valid_o[0] == 1'b0, "R8 vc0 emptied", rd_valid_o[0], 0);
    wr(1, 1, 32'hE002);
    chk(overflow_o[1] == 1'b0, "R8 freed space used", overflow_o[1], 0);
    for (int i = 0; i < 3; i++) begin
      rd(1, 1);
      chk(rd_valid_o[1] && rd_flit_o[1] == 32'hE000 + i, "R6 R2 vc5 order", rd_flit_o[1], 32'hE000 + i);
    end
    rd(1, 1);
    chk(rd_valid_o[1] == 1'b0, "R6 dropped not stored", rd_valid_o[1], 0);
  endtask

  task automatic t_refill();
    fill_vc0("R11 full capacity back");
    wr(0, 0, 32'hDEAD);
    chk(overflow_o[0] == 1'b1, "R11 limit again", overflow_o[0], 1);
    dead_vc_i[0] = 1'b1;
    cyc();
    dead_vc_i[0] = 1'b0;
    #1;
    chk(credit_o == 8'hFF, "R11 all credit", credit_o, 8'hFF);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc();
    t_reset();
    t_empty_read();
    t_fifo();
    t_dual();
    t_share();
    t_purge();
    t_refill();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule